// File: doc/BRIEF.md
# Micro-Packet Transport Stream Reassembler

A capture engine delivers 32-bit words, each holding a small fragment of a 188-byte transport stream packet, with fragments from up to four tuner channels interleaved in one stream. This block sorts the words by channel and rebuilds whole packets. It keeps each channel's assembly state separate, so an interleaved stream needs no external reordering.

Each word carries a 3-bit tag (channel number plus one), a start flag and three payload bytes. A channel ignores fragments until it sees a start flag. After the 63rd fragment, which supplies only two bytes, the 188-byte packet is complete. The block then drains it onto a byte-wide valid/ready stream that carries the channel number and first-byte and last-byte markers. A masked write port turns channels on and off. A sticky flag per channel records packets lost to back-pressure. A counter per channel counts packets whose first byte is not the 0x47 sync byte.

Top module: `tsr_reasm`

## Requirements
- R1: Word bits 31:29 carry the channel number plus one. A tag of 0, 5, 6 or 7 marks a word that is discarded with no effect on any channel.
- R2: Word bit 25 is the start flag. A start word always restarts its channel at fragment slot 0. A non-start word that reaches a channel with no packet in progress is dropped.
- R3: Payload bytes are taken in the order bits 23:16, 15:8, 7:0. Fragment slots 0 to 61 contribute three bytes each. Slot 62 contributes only bits 23:16 and 15:8, which gives a 188-byte packet.
- R4: After slot 62 is stored, the channel accepts nothing until a new start word arrives.
- R5: A control write sets enable bit i (i = 0..3) to data bit i only where mask bit 8+i is set. All enables are 0 after reset, and the enables are visible on `chan_en`.
- R6: Words for a disabled channel are discarded, and disabling a channel abandons its partial packet.
- R7: A finished packet leaves as 188 bytes on `ts_*` with its channel number. `ts_sop` marks the first byte and `ts_eop` the last. All outputs hold steady while `ts_ready` is low.
- R8: When several packets are waiting, the lowest channel number is drained first.
- R9: A start word that arrives for a channel whose finished packet has not yet been drained is dropped. It sets that channel's sticky bit in `ovf_flag`, and the waiting packet is left intact.
- R10: Each packet whose first byte is not 0x47 is still forwarded, and it increments that channel's saturating counter in `sync_err_cnt[8*i +: 8]`.
- R11: After reset, `ts_valid`, `ovf_flag`, `chan_en` and all sync-error counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uw_valid | input | 1 | Micro-packet word present this cycle |
| uw_data | input | 32 | Micro-packet word |
| ctl_we | input | 1 | Enable-register write strobe |
| ctl_data | input | 16 | Write data: bits 3:0 values, bits 11:8 masks |
| chan_en | output | 4 | Current channel enables |
| ts_valid | output | 1 | Output byte valid |
| ts_ready | input | 1 | Downstream accepts byte |
| ts_data | output | 8 | Output byte |
| ts_chan | output | 2 | Channel of the packet being output |
| ts_sop | output | 1 | First byte of packet |
| ts_eop | output | 1 | Last byte of packet |
| ovf_flag | output | 4 | Sticky per-channel overflow flags |
| sync_err_cnt | output | 32 | Four 8-bit sync-error counters, channel i at bits 8i+7:8i |

## Verification
A wrong fragment counter shows up at the ports only when that channel's packet drains. It appears as a shifted or missing byte, a packet that never ends, or a packet that appears without a start word. For this reason every packet is compared byte by byte, and the quiet windows after ignored traffic are watched for stray output. A wrong pending or arbitration state shows up within a few cycles of the packet completing, as the wrong `ts_chan` or as a packet overwritten by later traffic. The interleaving, overflow and ordering scenarios target exactly those faults.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    // Word format constants (fixed by the capture engine)
    localparam int NCH       = 4;
    localparam int CH_W      = 2;
    localparam int TAG_HI    = 31;
    localparam int TAG_LO    = 29;
    localparam int START_BIT = 25;
    localparam logic [7:0] SYNC_BYTE = 8'h47;

    typedef struct packed {
        logic            ok;
        logic [CH_W-1:0] ch;
        logic            start;
        logic [7:0]      b_hi;
        logic [7:0]      b_mid;
        logic [7:0]      b_lo;
    } uword_t;

    function automatic uword_t decode_word(input logic [31:0] w);
        uword_t d;
        logic [2:0] tag;
        tag     = w[TAG_HI:TAG_LO];
        d.ok    = (tag != 3'd0) && (int'(tag) <= NCH);
        d.ch    = CH_W'(tag - 3'd1);
        d.start = w[START_BIT];
        d.b_hi  = w[23:16];
        d.b_mid = w[15:8];
        d.b_lo  = w[7:0];
        return d;
    endfunction
endpackage

// File: rtl/tsr_chan_ctx.sv
module tsr_chan_ctx #(
    parameter  int UPK   = 63,
    localparam int CNT_W = $clog2(UPK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             hit,
    input  logic             start,
    input  logic             clr_pend,
    output logic             store,
    output logic [CNT_W-1:0] slot,
    output logic             pend,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UPK - 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        store = en && hit && !pend && (start || cnt != '0);
        slot  = start ? '0 : cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (clr_pend)
                pend <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (hit) begin
                if (pend) begin
                    if (start)
                        ovf <= 1'b1;
                end else if (store) begin
                    if (slot == LAST) begin
                        cnt  <= '0;
                        pend <= 1'b1;
                    end else begin
                        cnt <= slot + CNT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tsr_drain.sv
module tsr_drain #(
    parameter  int NCH       = 4,
    parameter  int PKT_BYTES = 188,
    parameter  int SERR_W    = 8,
    localparam int CH_W      = $clog2(NCH),
    localparam int IDX_W     = $clog2(PKT_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        pend,
    input  logic [7:0]            rd_byte,
    output logic [CH_W-1:0]       rd_ch,
    output logic [IDX_W-1:0]      rd_idx,
    input  logic                  ts_ready,
    output logic                  ts_valid,
    output logic [7:0]            ts_data,
    output logic [CH_W-1:0]       ts_chan,
    output logic                  ts_sop,
    output logic                  ts_eop,
    output logic [NCH-1:0]        clr_pend,
    output logic [NCH*SERR_W-1:0] sync_err_cnt
);
    import tsr_pkg::SYNC_BYTE;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

    logic              busy;
    logic [CH_W-1:0]   cur, sel;
    logic [IDX_W-1:0]  idx;
    logic [SERR_W-1:0] serr [NCH];
    logic              fire;

    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (pend[i]) sel = CH_W'(i);
    end

    assign fire     = busy && ts_ready;
    assign rd_ch    = cur;
    assign rd_idx   = idx;
    assign ts_valid = busy;
    assign ts_data  = rd_byte;
    assign ts_chan  = cur;
    assign ts_sop   = busy && idx == '0;
    assign ts_eop   = busy && idx == LAST_IDX;

    always_comb begin
        clr_pend = '0;
        if (fire && idx == LAST_IDX) clr_pend[cur] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
            idx  <= '0;
        end else if (!busy) begin
            if (|pend) begin
                busy <= 1'b1;
                cur  <= sel;
                idx  <= '0;
            end
        end else if (fire) begin
            if (idx == LAST_IDX) busy <= 1'b0;
            else                 idx  <= idx + IDX_W'(1);
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_serr
        always_ff @(posedge clk) begin
            if (rst)
                serr[g] <= '0;
            else if (fire && idx == '0 && cur == CH_W'(g) &&
                     rd_byte != SYNC_BYTE && serr[g] != '1)
                serr[g] <= serr[g] + SERR_W'(1);
        end
        assign sync_err_cnt[g*SERR_W +: SERR_W] = serr[g];
    end
endmodule

// File: rtl/tsr_reasm.sv
module tsr_reasm #(
    parameter int UPK    = 63,
    parameter int SERR_W = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            uw_valid,
    input  logic [31:0]                     uw_data,
    input  logic                            ctl_we,
    input  logic [15:0]                     ctl_data,
    output logic [tsr_pkg::NCH-1:0]         chan_en,
    output logic                            ts_valid,
    input  logic                            ts_ready,
    output logic [7:0]                      ts_data,
    output logic [tsr_pkg::CH_W-1:0]        ts_chan,
    output logic                            ts_sop,
    output logic                            ts_eop,
    output logic [tsr_pkg::NCH-1:0]         ovf_flag,
    output logic [tsr_pkg::NCH*SERR_W-1:0]  sync_err_cnt
);
    import tsr_pkg::*;

    localparam int PKT_BYTES = 3 * UPK - 1;
    localparam int CNT_W     = $clog2(UPK);
    localparam int IDX_W     = $clog2(PKT_BYTES);
    localparam int MEM_N     = NCH * PKT_BYTES;
    localparam int MEM_AW    = $clog2(MEM_N);

    uword_t            dec;
    logic [NCH-1:0]    hit_v, store_v, pend_v, clr_v;
    logic [CNT_W-1:0]  slot_v [NCH];
    logic [CNT_W-1:0]  wslot;
    logic [MEM_AW-1:0] wbase, raddr;
    logic [CH_W-1:0]   rd_ch;
    logic [IDX_W-1:0]  rd_idx;
    logic [7:0]        pkt_mem [MEM_N];
    logic              unused_bits;

    assign dec         = decode_word(uw_data);
    assign unused_bits = ^{uw_data[28:26], uw_data[24], ctl_data[15:12], ctl_data[7:4]};

    // Masked enable register
    always_ff @(posedge clk) begin
        if (rst)
            chan_en <= '0;
        else if (ctl_we)
            chan_en <= (ctl_data[NCH-1:0] & ctl_data[8 +: NCH]) |
                       (chan_en & ~ctl_data[8 +: NCH]);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ctx
        assign hit_v[g] = uw_valid && dec.ok && dec.ch == CH_W'(g);
        tsr_chan_ctx #(.UPK(UPK)) ctx_i (
            .clk      (clk),
            .rst      (rst),
            .en       (chan_en[g]),
            .hit      (hit_v[g]),
            .start    (dec.start),
            .clr_pend (clr_v[g]),
            .store    (store_v[g]),
            .slot     (slot_v[g]),
            .pend     (pend_v[g]),
            .ovf      (ovf_flag[g])
        );
    end

    assign wslot = slot_v[dec.ch];
    assign wbase = MEM_AW'(dec.ch) * MEM_AW'(PKT_BYTES) + MEM_AW'(wslot) * MEM_AW'(3);
    assign raddr = MEM_AW'(rd_ch) * MEM_AW'(PKT_BYTES) + MEM_AW'(rd_idx);

    always_ff @(posedge clk) begin
        if (|store_v) begin
            pkt_mem[wbase]               <= dec.b_hi;
            pkt_mem[wbase + MEM_AW'(1)]  <= dec.b_mid;
            if (wslot != CNT_W'(UPK - 1))
                pkt_mem[wbase + MEM_AW'(2)] <= dec.b_lo;
        end
    end

    tsr_drain #(.NCH(NCH), .PKT_BYTES(PKT_BYTES), .SERR_W(SERR_W)) drain_i (
        .clk          (clk),
        .rst          (rst),
        .pend         (pend_v),
        .rd_byte      (pkt_mem[raddr]),
        .rd_ch        (rd_ch),
        .rd_idx       (rd_idx),
        .ts_ready     (ts_ready),
        .ts_valid     (ts_valid),
        .ts_data      (ts_data),
        .ts_chan      (ts_chan),
        .ts_sop       (ts_sop),
        .ts_eop       (ts_eop),
        .clr_pend     (clr_v),
        .sync_err_cnt (sync_err_cnt)
    );
endmodule

// File: rtl/tsr_reasm_chk.sv
module tsr_reasm_chk (
    input logic       clk,
    input logic       rst,
    input logic       ts_valid,
    input logic       ts_ready,
    input logic [7:0] ts_data,
    input logic [1:0] ts_chan,
    input logic       ts_sop,
    input logic       ts_eop,
    input logic [3:0] ovf_flag,
    input logic       ctl_we,
    input logic [3:0] ctl_val,
    input logic [3:0] ctl_mask,
    input logic [3:0] chan_en
);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ts_valid && !ts_ready |=> ts_valid && $stable(ts_data) && $stable(ts_chan)
                                   && $stable(ts_sop) && $stable(ts_eop));

    // R7
    sop_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
        ts_valid && ts_ready && ts_eop |=> !ts_valid || ts_sop);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (|ovf_flag) |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag)));

    // R5
    masked_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> chan_en == (($past(ctl_val) & $past(ctl_mask)) |
                               ($past(chan_en) & ~$past(ctl_mask))));

    // R5
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> $stable(chan_en));
endmodule

bind tsr_reasm tsr_reasm_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .ts_valid (ts_valid),
    .ts_ready (ts_ready),
    .ts_data  (ts_data),
    .ts_chan  (ts_chan),
    .ts_sop   (ts_sop),
    .ts_eop   (ts_eop),
    .ovf_flag (ovf_flag),
    .ctl_we   (ctl_we),
    .ctl_val  (ctl_data[3:0]),
    .ctl_mask (ctl_data[11:8]),
    .chan_en  (chan_en)
);

// File: tb/tsr_reasm_tb_top.sv
module tsr_reasm_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        uw_valid = 1'b0;
    logic [31:0] uw_data = '0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_data = '0;
    logic [3:0]  chan_en;
    logic        ts_valid, ts_ready = 1'b0;
    logic [7:0]  ts_data;
    logic [1:0]  ts_chan;
    logic        ts_sop, ts_eop;
    logic [3:0]  ovf_flag;
    logic [31:0] sync_err_cnt;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tsr_reasm dut_i (.*);

    // ch, seed, first byte
    localparam logic [17:0] VEC [4] = '{
        {2'd0, 8'h10, 8'h47},
        {2'd2, 8'h33, 8'h47},
        {2'd3, 8'h80, 8'h47},
        {2'd1, 8'h05, 8'h12}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] seed, input logic [7:0] first, input int j);
        return (j == 0) ? first : 8'(int'(seed) + j);
    endfunction

    task automatic cfg_write(input logic [15:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_data = d;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    function automatic logic [31:0] mk_word(input logic [1:0] ch, input bit st,
                                            input logic [7:0] b2, input logic [7:0] b1, input logic [7:0] b0);
        return {3'(ch) + 3'd1, 3'b000, st, 1'b0, b2, b1, b0};
    endfunction

    // Sends fragments k_lo..k_hi; start flag on k==k_lo when st_first set; junk words interleaved if junk
    task automatic send_frags(input logic [1:0] ch, input logic [7:0] seed, input logic [7:0] first,
                              input int k_lo, input int k_hi, input bit st_first, input bit junk);
        for (int k = k_lo; k <= k_hi; k++) begin
            @(negedge clk);
            uw_valid = 1'b1;
            uw_data  = mk_word(ch, st_first && k == k_lo, exp_byte(seed, first, 3*k),
                               exp_byte(seed, first, 3*k+1),
                               (k == 62) ? 8'hAA : exp_byte(seed, first, 3*k+2));
            if (junk) begin
                @(negedge clk);
                uw_data = {(k % 2 == 0) ? 3'd0 : 3'(5 + k % 3), 3'b000, 1'b1, 1'b0, 24'hFFFFFF};
            end
        end
        @(negedge clk); uw_valid = 1'b0;
    endtask

    task automatic collect(input logic [1:0] ch, input logic [7:0] seed, input logic [7:0] first,
                           input bit bp, input string tag);
        int got = 0, bad_d = 0, bad_f = 0, bad_c = 0, guard = 0;
        while (got < 188 && guard < 3000) begin
            @(negedge clk);
            guard++;
            ts_ready = bp ? (guard % 3 != 0) : 1'b1;
            #1;
            if (ts_valid && ts_ready) begin
                if (ts_data != exp_byte(seed, first, got)) bad_d++;
                if (ts_sop != (got == 0) || ts_eop != (got == 187)) bad_f++;
                if (ts_chan != ch) bad_c++;
                got++;
            end
        end
        @(posedge clk); #1 ts_ready = 1'b0;
        chk(bad_d == 0, {"R3 data ", tag}, bad_d, 0);
        chk(bad_f == 0, {"R7 framing ", tag}, bad_f, 0);
        chk(bad_c == 0 && got == 188, {"R1 channel/count ", tag}, {bad_c, got}, 188);
    endtask

    task automatic no_output(input int n, input string req);
        int seen = 0;
        repeat (n) begin @(negedge clk); if (ts_valid) seen++; end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R11 reset state
        chk(!ts_valid && ovf_flag == 0 && chan_en == 0 && sync_err_cnt == 0, "R11 reset",
            {ts_valid, ovf_flag, chan_en}, 0);

        // R5 masked enable writes
        cfg_write(16'h0F0F); chk(chan_en == 4'hF, "R5 all on", chan_en, 4'hF);
        cfg_write(16'h0500); chk(chan_en == 4'hA, "R5 mask off", chan_en, 4'hA);
        cfg_write(16'h0105); chk(chan_en == 4'hB, "R5 unmasked ignored", chan_en, 4'hB);
        cfg_write(16'h0404); chk(chan_en == 4'hF, "R5 reenable", chan_en, 4'hF);

        // Vector table walk: R1 R3 R7 R10
        foreach (VEC[i]) begin
            send_frags(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], 0, 62, 1'b1, 1'b0);
            collect(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], 1'b0, "table");
        end
        chk(sync_err_cnt == 32'h0000_0100, "R10 sync errors", sync_err_cnt, 32'h0000_0100);

        // R1 invalid tags interleaved
        send_frags(2'd0, 8'h21, 8'h47, 0, 62, 1'b1, 1'b1);
        collect(2'd0, 8'h21, 8'h47, 1'b0, "R1 junk");

        // R2 unsynced words dropped, then restart mid-packet
        send_frags(2'd2, 8'h99, 8'h47, 5, 20, 1'b0, 1'b0);
        no_output(20, "R2 unsynced");
        send_frags(2'd2, 8'h99, 8'h47, 0, 19, 1'b1, 1'b0);
        send_frags(2'd2, 8'h44, 8'h47, 0, 62, 1'b1, 1'b0);
        collect(2'd2, 8'h44, 8'h47, 1'b0, "R2 restart");

        // R4 waits for start after completion
        send_frags(2'd1, 8'h60, 8'h47, 0, 62, 1'b0, 1'b0);
        no_output(20, "R4 no start");

        // R6 disable
        cfg_write(16'h0800);
        send_frags(2'd3, 8'h70, 8'h47, 0, 62, 1'b1, 1'b0);
        no_output(20, "R6 disabled");
        cfg_write(16'h0808);
        send_frags(2'd3, 8'h70, 8'h47, 0, 29, 1'b1, 1'b0);
        cfg_write(16'h0800);
        cfg_write(16'h0808);
        send_frags(2'd3, 8'h70, 8'h47, 30, 62, 1'b0, 1'b0);
        no_output(20, "R6 partial abandoned");

        // R8 priority: ch3 blocks drain, ch2 then ch1 wait
        send_frags(2'd3, 8'h01, 8'h47, 0, 62, 1'b1, 1'b0);
        send_frags(2'd2, 8'h02, 8'h47, 0, 62, 1'b1, 1'b0);
        send_frags(2'd1, 8'h03, 8'h47, 0, 62, 1'b1, 1'b0);
        collect(2'd3, 8'h01, 8'h47, 1'b0, "R8 first");
        collect(2'd1, 8'h03, 8'h47, 1'b0, "R8 lowest next");
        collect(2'd2, 8'h02, 8'h47, 1'b0, "R8 last");

        // R9 overflow
        chk(ovf_flag == 0, "R9 none yet", ovf_flag, 0);
        send_frags(2'd0, 8'hC0, 8'h47, 0, 62, 1'b1, 1'b0);
        send_frags(2'd0, 8'hD0, 8'h47, 0, 62, 1'b1, 1'b0);
        chk(ovf_flag == 4'b0001, "R9 flag", ovf_flag, 1);
        collect(2'd0, 8'hC0, 8'h47, 1'b0, "R9 intact");
        no_output(20, "R9 dropped");

        // R7 back-pressure
        send_frags(2'd1, 8'h55, 8'h47, 0, 62, 1'b1, 1'b0);
        collect(2'd1, 8'h55, 8'h47, 1'b1, "R7 backpressure");
        chk(ovf_flag == 4'b0001, "R9 sticky", ovf_flag, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule